// File: doc/BRIEF.md
# Rewindable Byte Buffer with Half-Occupancy Flag

This block is a single-clock first-in/first-out buffer of 9-bit words. It sits between a capture side that delivers words in bursts and a slow serial side that drains them one at a time. Eight bits carry a byte and the ninth is spare, free for parity or a marker. The write side presents a word together with a write strobe. The read side raises a read strobe and finds the word on the data output after the next clock edge.

Three active-low status flags report the buffer state: empty, full, and more-than-half occupied. A rewind pulse puts the read position back at the first location written since reset and leaves the write position where it is. The whole block captured since reset can then be drained a second time, for example after the serial link lost part of it. The depth is a power-of-two parameter and defaults to 4096 words.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_data` is 0. Both positions return to the first location.
- R2: Words leave in the order they were accepted, with all 9 bits intact.
- R3: A write strobe raised while `full_n` is 0 is ignored, even when a read is accepted in the same cycle.
- R4: A read strobe raised while `empty_n` is 0 is ignored, and `rd_data` keeps its previous value.
- R5: Starting from reset with no reads, `full_n` stays 1 for the first DEPTH-1 writes and falls to 0 after write number DEPTH.
- R6: `half_n` falls on the write that takes the occupancy from DEPTH/2 to DEPTH/2+1. It stays 0 until an accepted read brings the occupancy back to DEPTH/2 or lower, and that read raises it.
- R7: With the buffer neither empty nor full, a cycle with both strobes accepts both. The occupancy and all three flags stay as they were.
- R8: A cycle with `rewind` high moves the read position to the first location and leaves the write position unchanged. Both strobes are ignored in that cycle. The flags then reflect an occupancy equal to the number of writes since reset, which must be fewer than DEPTH.
- R9: The flags and `rd_data` change only on a clock edge. A word written into an empty buffer can be read in the very next cycle.
- R10: After one read from a full buffer, a write in the very next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 9 | Word from the most recent accepted read |
| rewind | input | 1 | Return the read position to the first location |
| empty_n | output | 1 | Low when no word is held |
| full_n | output | 1 | Low when DEPTH words are held |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
Some properties are checked on every cycle. A flag can only move toward full or half-full through a write. An empty or full buffer stays that way while the strobe that could change it is absent, and `rd_data` holds while the buffer is empty. A cycle with both strobes on a partly filled buffer leaves the flags untouched. The order of the data, the exact write count at which the full and half flags switch, and the rewind replaying the same words with the strobes of that cycle dropped can only be shown by the bench's scenarios.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
    // Word width: one byte plus one spare bit for parity or a marker (R2).
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rewind_fifo_ctrl.sv
// Position and flag control: one combinational process builds the next
// state, one register process stores it.
module rewind_fifo_ctrl #(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic                       rewind,
    output logic                       wr_go,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic                       rd_go,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic                       empty_n,
    output logic                       full_n,
    output logic                       half_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HALF_MARK = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] wpos;
        logic [PW-1:0] rpos;
        logic          empty_n;
        logic          full_n;
        logic          half_n;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [PW-1:0] occ_d;
    logic          wr_take, rd_take;

    always_comb begin
        st_d    = st_q;
        // R3/R4: a strobe counts only when its flag allows it;
        // R8: neither counts in a rewind cycle.
        wr_take = wr_en && st_q.full_n  && !rewind;
        rd_take = rd_en && st_q.empty_n && !rewind;

        if (rewind) begin
            st_d.rpos = '0;                      // R8: write position kept
        end else begin
            if (wr_take) st_d.wpos = st_q.wpos + 1'b1;
            if (rd_take) st_d.rpos = st_q.rpos + 1'b1;
        end

        // Extra top bit separates "same slot, empty" from "same slot, full".
        st_d.empty_n = (st_d.wpos != st_d.rpos);
        st_d.full_n  = !((st_d.wpos[PW-1] != st_d.rpos[PW-1]) &&
                         (st_d.wpos[AW-1:0] == st_d.rpos[AW-1:0]));
        // R6: set by the write past the midpoint, cleared by the read back to it.
        occ_d        = st_d.wpos - st_d.rpos;
        st_d.half_n  = !(occ_d > HALF_MARK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wpos    <= '0;
            st_q.rpos    <= '0;
            st_q.empty_n <= 1'b0;     // R1
            st_q.full_n  <= 1'b1;
            st_q.half_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_go   = wr_take;
    assign rd_go   = rd_take;
    assign wr_addr = st_q.wpos[AW-1:0];
    assign rd_addr = st_q.rpos[AW-1:0];
    assign empty_n = st_q.empty_n;
    assign full_n  = st_q.full_n;
    assign half_n  = st_q.half_n;
endmodule

// File: rtl/rewind_fifo_store.sv
// Word storage with a registered read port.
module rewind_fifo_store
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_go,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr,
    input  word_t                      wr_word,
    input  logic                       rd_go,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output word_t                      rd_word
);
    word_t mem [DEPTH];
    word_t out_d, out_q;

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= wr_word;
    end

    always_comb begin
        out_d = out_q;                       // R4: held when no read is taken
        if (rd_go) out_d = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;             // R1
        else        out_q <= out_d;
    end

    assign rd_word = out_q;
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rewind,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_go, rd_go;
    logic [AW-1:0] wr_addr, rd_addr;

    rewind_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rewind  (rewind),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    rewind_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_word (wr_data),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       rewind,
    input logic [8:0] rd_data,
    input logic       empty_n,
    input logic       full_n,
    input logic       half_n
);
    // R4: an empty buffer stays empty and the output holds without a write.
    a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_en && !rewind) |=> (!empty_n && $stable(rd_data)));

    // R3: a full buffer stays full without a read.
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_en && !rewind) |=> !full_n);

    // R5: full can only be reached through a write.
    a_r5_full_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (full_n && !wr_en && !rewind) |=> full_n);

    // R6: half-full is held until a read, and is only set by a write.
    a_r6_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_n && !rd_en && !rewind) |=> !half_n);
    a_r6_half_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (half_n && !wr_en && !rewind) |=> half_n);

    // R7: a paired read and write on a partly filled buffer keeps every flag.
    a_r7_pair_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_n && full_n && wr_en && rd_en && !rewind) |=>
        (empty_n && full_n && (half_n == $past(half_n))));

    // R9: the flags never contradict each other.
    a_r9_flags_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_n || full_n) && (empty_n || half_n));
endmodule

bind rewind_fifo rewind_fifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rewind  (rewind),
    .rd_data (rd_data),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
);

// File: tb/rewind_fifo_test.sv
`timescale 1ns/1ps
module rewind_fifo_test;
    localparam int TB_DEPTH = 8;
    localparam int TB_HALF  = TB_DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       empty_n, full_n, half_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rewind_fifo #(.DEPTH(TB_DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rewind(rewind),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    typedef struct packed {
        logic       wr;
        logic [8:0] wd;
        logic       rd;
        logic       e;
        logic       f;
        logic       h;
        logic [8:0] q;
        logic       cq;
    } vec_t;

    // Depth 8, midpoint 4. Flags are the values after the edge.
    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 9'h1A5, 1'b0, 1'b1, 1'b1, 1'b1, 9'h000, 1'b0}, // R9 write into empty
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 1'b1, 9'h1A5, 1'b1}, // R9 read next cycle
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 1'b1, 9'h1A5, 1'b1}, // R4 read while empty
        '{1'b1, 9'h100, 1'b0, 1'b1, 1'b1, 1'b1, 9'h1A5, 1'b1}, // R2 occ 1
        '{1'b1, 9'h0FF, 1'b0, 1'b1, 1'b1, 1'b1, 9'h1A5, 1'b1}, // occ 2
        '{1'b1, 9'h055, 1'b1, 1'b1, 1'b1, 1'b1, 9'h100, 1'b1}, // R7 pair, occ 2
        '{1'b1, 9'h0AA, 1'b0, 1'b1, 1'b1, 1'b1, 9'h100, 1'b1}, // occ 3
        '{1'b1, 9'h133, 1'b0, 1'b1, 1'b1, 1'b1, 9'h100, 1'b1}, // R6 occ 4, not yet
        '{1'b1, 9'h01E, 1'b0, 1'b1, 1'b1, 1'b0, 9'h100, 1'b1}, // R6 occ 5 sets
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0FF, 1'b1}, // R6 read to 4 clears
        '{1'b1, 9'h1C3, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0FF, 1'b1}, // occ 5
        '{1'b1, 9'h002, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0FF, 1'b1}, // occ 6
        '{1'b1, 9'h003, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0FF, 1'b1}, // occ 7
        '{1'b1, 9'h004, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0FF, 1'b1}, // occ 8 full
        '{1'b1, 9'h005, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0FF, 1'b1}, // R3 write while full
        '{1'b1, 9'h1EE, 1'b1, 1'b1, 1'b1, 1'b0, 9'h055, 1'b1}, // R3 pair on full, write dropped
        '{1'b1, 9'h006, 1'b0, 1'b1, 1'b0, 1'b0, 9'h055, 1'b1}, // R10 write next cycle
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0AA, 1'b1}, // R2 drain
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h133, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h01E, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1C3, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h002, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h003, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h004, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 1'b1, 9'h006, 1'b1}  // R2 last word, empty
    };

    task automatic check(input string what, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Drive one cycle of inputs after a falling edge, then wait past the rising edge.
    task automatic cyc(input logic w, input logic [8:0] d, input logic r, input logic rw);
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; rewind = rw;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 empty_n in reset", {8'd0, empty_n}, 9'd0);
        check("R1 full_n in reset",  {8'd0, full_n},  9'd1);
        check("R1 half_n in reset",  {8'd0, half_n},  9'd1);
        check("R1 rd_data in reset", rd_data, 9'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();

        // Vector table: R2, R3, R4, R6, R7, R9, R10
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].wr, VEC[i].wd, VEC[i].rd, 1'b0);
            check($sformatf("vec %0d empty_n", i), {8'd0, empty_n}, {8'd0, VEC[i].e});
            check($sformatf("vec %0d full_n", i),  {8'd0, full_n},  {8'd0, VEC[i].f});
            check($sformatf("vec %0d half_n", i),  {8'd0, half_n},  {8'd0, VEC[i].h});
            if (VEC[i].cq)
                check($sformatf("vec %0d rd_data", i), rd_data, VEC[i].q);
        end

        // R1: reset after activity clears the output word and flags
        do_reset();

        // R5 and R6: fill with no reads
        for (int i = 0; i < TB_DEPTH; i++) begin
            cyc(1'b1, 9'(9'h080 + i), 1'b0, 1'b0);
            check($sformatf("R5 full_n after write %0d", i + 1), {8'd0, full_n},
                  (i == TB_DEPTH - 1) ? 9'd0 : 9'd1);
            check($sformatf("R6 half_n after write %0d", i + 1), {8'd0, half_n},
                  (i >= TB_HALF) ? 9'd0 : 9'd1);
        end

        // R8: rewind replays, strobes in the rewind cycle dropped
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1'b1, 9'(9'h140 + i), 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 9'h000, 1'b1, 1'b0);
            check("R8 data before rewind", rd_data, 9'(9'h140 + i));
        end
        check("R8 half_n before rewind", {8'd0, half_n}, 9'd1);
        cyc(1'b1, 9'h1FF, 1'b1, 1'b1);
        check("R8 rd_data unchanged by rewind", rd_data, 9'h142);
        check("R8 empty_n after rewind", {8'd0, empty_n}, 9'd1);
        check("R8 full_n after rewind",  {8'd0, full_n},  9'd1);
        check("R8 half_n after rewind",  {8'd0, half_n},  9'd0);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 9'h000, 1'b1, 1'b0);
            check("R8 replayed data", rd_data, 9'(9'h140 + i));
        end
        check("R8 empty after replay, dropped write absent", {8'd0, empty_n}, 9'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule